// File: doc/BRIEF.md
# Universal Shift Register with Shared I/O

This block is an eight-bit register with four operations: it can keep its contents, shift toward the high end, shift toward the low end, or take a full word from a shared parallel bus. A separate active-low clear empties the register on the next clock edge. The clear takes priority over every operation.

The parallel bus is bidirectional. The same lines carry the register contents out and bring load data in. Inside the block the bus is modelled as three signals: an input vector, an output vector and a single drive-enable. The enclosing level builds the tri-state buffer from these.

The lowest and highest bits also have their own serial outputs, and each end has its own serial input. Two or more blocks can therefore be chained into a longer shifter. Shifting, loading, holding and clearing all work the same way whether or not the bus is being driven.

Top module: `univ_shift_reg`

## Requirements
- R1: When `clr_n` is low at a rising edge of `clk`, all register bits become 0 after that edge, whatever value `sel` has.
- R2: With `clr_n` high and `sel` = 2'b00, the register keeps its value across the edge.
- R3: With `clr_n` high and `sel` = 2'b01, bit 0 takes `ser_r_in` and every bit n takes the old bit n-1.
- R4: With `clr_n` high and `sel` = 2'b10, bit WIDTH-1 takes `ser_l_in` and every bit n takes the old bit n+1.
- R5: With `clr_n` high and `sel` = 2'b11, the register takes the value on `bus_in`.
- R6: `bus_oe` is low whenever `oe_a_n` or `oe_b_n` is high.
- R7: `bus_oe` is low whenever `sel` = 2'b11.
- R8: In every other case `bus_oe` is high. `bus_out` always equals the current register contents.
- R9: `lsb_out` always shows register bit 0 and `msb_out` always shows bit WIDTH-1, whatever the state of `bus_oe`.
- R10: All four operations and the clear update the register in the same way while `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low. Overrides `sel` |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Second bus output enable, active low |
| ser_r_in | input | 1 | Serial bit that enters bit 0 during a shift up |
| ser_l_in | input | 1 | Serial bit that enters bit WIDTH-1 during a shift down |
| bus_in | input | WIDTH | Value seen on the shared bus, used for loading |
| bus_out | output | WIDTH | Register contents to drive onto the shared bus |
| bus_oe | output | 1 | High when the bus should be driven |
| lsb_out | output | 1 | Register bit 0, for chaining |
| msb_out | output | 1 | Register bit WIDTH-1, for chaining |

## Verification
Register results (R1 to R5, R9, R10) show up exactly one rising edge after the inputs that cause them. The bench drives each set of inputs one time unit after an edge, advances its reference model for the coming edge, and compares at one time unit after that edge. `bus_oe` has no register in its path, so the bench checks it one time unit after driving the inputs, before the edge. Two instances are chained into a sixteen-bit shifter, so every shift also exercises the serial outputs crossing the boundary between the instances.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift register.
// Assumes the operation field is two bits wide, with encodings fixed as below.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_next_state.sv
// Next-state logic for each bit of the register.
// Computes the value the register takes at the coming edge from the current
// contents, the operation, the clear and both serial inputs. Purely combinational.
// Assumes WIDTH >= 2.
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  usr_mode_e        mode,
    input  logic             clr_n,
    input  logic             shr_in,
    input  logic             shl_in,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_lo;
        logic from_hi;
        logic bit_nx;

        // Neighbour below: the serial input at bit 0, otherwise bit i-1.
        if (i == 0) begin : g_lo_edge
            assign from_lo = shr_in;
        end else begin : g_lo_mid
            assign from_lo = cur[i-1];
        end

        // Neighbour above: the serial input at the top bit, otherwise bit i+1.
        if (i == TOP) begin : g_hi_edge
            assign from_hi = shl_in;
        end else begin : g_hi_mid
            assign from_hi = cur[i+1];
        end

        // Select this bit's next value; the clear takes priority.
        always_comb begin
            if (!clr_n) begin
                bit_nx = 1'b0;
            end else begin
                unique case (mode)
                    MODE_SHR:  bit_nx = from_lo;
                    MODE_SHL:  bit_nx = from_hi;
                    MODE_LOAD: bit_nx = load_val[i];
                    default:   bit_nx = cur[i];
                endcase
            end
        end

        assign nxt[i] = bit_nx;
    end

endmodule

// File: rtl/usr_bus_ctrl.sv
// Drive-enable for the shared parallel bus.
// The bus is driven only when both active-low enables are low and the
// operation is not a load. Combinational, so it responds in the same cycle.
module usr_bus_ctrl
    import usr_pkg::*;
(
    input  logic      oe_a_n,
    input  logic      oe_b_n,
    input  usr_mode_e mode,
    output logic      drive
);

    // Both enables must be active, and a load forces the bus off.
    always_comb begin
        drive = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);
    end

    // R7: a load never drives the bus.
    always_comb begin
        a_r7_load_off: assert (!(mode == MODE_LOAD && drive));
    end

endmodule

// File: rtl/univ_shift_reg.sv
// Universal shift register with a shared parallel bus.
// Holds WIDTH bits that can be kept, shifted in either direction, loaded from
// bus_in, or cleared on the clock edge. The surrounding level builds the
// tri-state buffer from bus_out and bus_oe. Chaining uses lsb_out, msb_out
// and the serial inputs.
// Assumes: a single clock; clr_n sampled synchronously; WIDTH >= 2.
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             lsb_out,
    output logic             msb_out
);

    localparam int TOP = WIDTH - 1;

    usr_mode_e        mode;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nx;

    assign mode = usr_mode_e'(sel);

    usr_next_state #(.WIDTH(WIDTH)) u_nx (
        .cur      (q_r),
        .mode     (mode),
        .clr_n    (clr_n),
        .shr_in   (ser_r_in),
        .shl_in   (ser_l_in),
        .load_val (bus_in),
        .nxt      (q_nx)
    );

    // Register state update on every rising edge.
    always_ff @(posedge clk) begin
        q_r <= q_nx;
    end

    usr_bus_ctrl u_bus (
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .mode   (mode),
        .drive  (bus_oe)
    );

    // Contents to the bus and the chaining outputs.
    assign bus_out = q_r;
    assign lsb_out = q_r[0];
    assign msb_out = q_r[TOP];

    // Goes high after the first edge, so $past never reaches before time zero.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q_r == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (mode == MODE_HOLD) |=> $stable(q_r));

    a_r3_shift_up: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (mode == MODE_SHR) |=> (q_r == {$past(q_r[TOP-1:0]), $past(ser_r_in)}));

    a_r4_shift_down: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (mode == MODE_SHL) |=> (q_r == {$past(ser_l_in), $past(q_r[TOP:1])}));

    a_r5_load: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (mode == MODE_LOAD) |=> (q_r == $past(bus_in)));

    a_r6_enable_off: assert property (@(posedge clk) disable iff (!armed)
        (oe_a_n || oe_b_n) |-> !bus_oe);

endmodule

// File: tb/sim_univ_shift_reg.sv
// Two instances chained into a 16-bit shifter and compared against a
// behavioural model after every edge.
module sim_univ_shift_reg;

    logic        clk = 1'b0;
    logic        clr_n;
    logic [1:0]  sel;
    logic        oe_a_n, oe_b_n;
    logic        sr_in, sl_in;
    logic [15:0] bus_drv;
    logic [7:0]  out_lo, out_hi;
    logic        oe_lo, oe_hi;
    logic        lsb_lo, msb_lo, lsb_hi, msb_hi;

    int total = 0;
    int bad   = 0;
    logic [15:0] model;

    always #2 clk = ~clk;

    univ_shift_reg #(.WIDTH(8)) u0 (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(sr_in), .ser_l_in(lsb_hi), .bus_in(bus_drv[7:0]),
        .bus_out(out_lo), .bus_oe(oe_lo), .lsb_out(lsb_lo), .msb_out(msb_lo)
    );

    univ_shift_reg #(.WIDTH(8)) u1 (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(msb_lo), .ser_l_in(sl_in), .bus_in(bus_drv[15:8]),
        .bus_out(out_hi), .bus_oe(oe_hi), .lsb_out(lsb_hi), .msb_out(msb_hi)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive inputs, check the enable at once, advance the model, then check after the edge.
    task automatic step(input string tag, input logic c, input logic [1:0] s,
                        input logic ea, input logic eb, input logic r, input logic l,
                        input logic [15:0] d);
        logic oe_exp;
        clr_n = c; sel = s; oe_a_n = ea; oe_b_n = eb; sr_in = r; sl_in = l; bus_drv = d;
        #1;
        oe_exp = !ea && !eb && (s != 2'b11);
        check(oe_exp ? "R8" : (s == 2'b11 ? "R7" : "R6"), {14'd0, oe_hi, oe_lo}, {14'd0, oe_exp, oe_exp});
        if (!c)            model = 16'h0000;
        else if (s == 2'b01) model = {model[14:0], r};
        else if (s == 2'b10) model = {l, model[15:1]};
        else if (s == 2'b11) model = d;
        @(posedge clk);
        #1;
        check(tag, {out_hi, out_lo}, model);
        check("R9", {12'd0, msb_hi, lsb_hi, msb_lo, lsb_lo},
              {12'd0, model[15], model[8], model[7], model[0]});
    endtask

    initial begin
        clr_n = 1'b0; sel = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0;
        sr_in = 1'b0; sl_in = 1'b0; bus_drv = 16'hFFFF; model = 16'h0000;
        @(posedge clk); #1;
        // R1: clear while a load is selected
        step("R1", 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        // R5: load a pattern
        step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3);
        // R2: hold with the bus driven
        for (int i = 0; i < 3; i++) step("R2", 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1234);
        // R3: shift up across the boundary between instances
        for (int i = 0; i < 20; i++) step("R3", 1'b1, 2'b01, 1'b0, 1'b0, 1'($urandom), 1'b0, 16'h0);
        // R4: shift down across the boundary between instances
        for (int i = 0; i < 20; i++) step("R4", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'($urandom), 16'h0);
        // R1: clear while a shift is selected
        step("R1", 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);
        // R10: operations with the bus disabled by either enable
        step("R10", 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 16'h6E19);
        for (int i = 0; i < 6; i++) step("R10", 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        step("R10", 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
        for (int i = 0; i < 5; i++) step("R10", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
        step("R10", 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0);
        // mixed random operations
        for (int i = 0; i < 200; i++)
            step("R2", ($urandom % 16) != 0, 2'($urandom), 1'($urandom % 4 == 0),
                 1'($urandom % 4 == 0), 1'($urandom), 1'($urandom), 16'($urandom));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule